// File: doc/BRIEF.md
# Serial PHY Management Register Front-End

This block lets a host reach the management registers of an Ethernet PHY through two memory-mapped registers. The host writes one 32-bit command word holding the PHY address, the PHY register number, the direction and, for a write, 16 data bits. The block then produces the management clock and shifts out a complete clause-22 frame on a tri-stated data line: preamble, start, opcode, addresses, turnaround and data. For a read it releases the line after the address bits, collects the 16 bits the PHY returns and puts them in the low half of the command register.

Progress is visible in the same command register. A busy flag stays set for the whole transaction, and a read-valid flag reports that captured read data sits in the data field. A second register holds a default PHY address of five bits for software's use. Both registers sit on a simple single-cycle bus with a write strobe and a combinational read path.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset busy and read-valid read as 0, the management clock is low, the data line is released (output enable 0) and the default address register reads back the DEFAULT_PHY parameter.
- R2: The default address register sits at offset 0x0. A write stores only bits 4:0 of the bus data, and reads return those five bits with bits 31:5 as zero.
- R3: A write to the command register at offset 0x4 while idle is accepted. From the next cycle busy (bit 28) reads 1, and the register reads back the op bit (26, 1 = read), register number (25:21), PHY address (20:16) and data field (15:0) that were written.
- R4: A command write while busy is 1 is ignored. Neither the stored fields nor the frame in progress change, and a write sampled in the cycle whose edge ends the transaction is also ignored.
- R5: Each transaction sends 64 bits, most significant first: 32 ones, start 01, opcode 10 for read or 01 for write, 5 PHY address bits, 5 register bits, turnaround 10 (write only), then 16 data bits. The data line changes only when the management clock falls, so it is stable at each rising edge.
- R6: The management clock has a period of 2*DIV_HALF system clocks while busy. It is low and the data line is released whenever busy is 0.
- R7: For a read the line is released from the first turnaround bit to the end of the frame. The 16 data bits are sampled on the rising management-clock edges of bits 48 to 63, placed in bits 15:0, and read-valid (bit 27) is set as busy clears.
- R8: Read-valid clears in the cycle after any command is accepted.
- R9: Busy clears exactly 128*DIV_HALF system clocks after the accepting edge, on the falling management-clock edge of the last bit.
- R10: A write transaction leaves read-valid at 0 and the data field holding the written data; the line is driven for all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for busAddr |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Data line value when driven |
| mdioOe | output | 1 | Data line drive enable (0 = released) |
| mdioIn | input | 1 | Data line value seen at the pin |

## Verification
Completion of a transaction and the acceptance of a new command meet in one cycle: the edge where the last bit's management clock falls clears busy, and a command write sampled at that same edge still sees busy set. The bench places a command write on precisely that edge, counted from the accepting edge of a read, and then expects an idle block whose fields still hold the finished read with read-valid set. A second write one cycle later must be accepted. The same read also checks that read-valid rises in the same cycle as busy falls, and that the captured data lands in the data field as the PHY model drove it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Frame layout, in bit positions counted from the first transmitted bit.
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int PRE_LEN   = 32;
  localparam int TURN_IDX  = 46;
  localparam int DATA_IDX  = 48;

  // Command word field positions.
  localparam int BIT_BUSY   = 28;
  localparam int BIT_RVALID = 27;
  localparam int BIT_OPRD   = 26;

  // Register byte offsets.
  localparam int OFS_PHYDEF = 0;
  localparam int OFS_CMD    = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;    // command accepted: latch fields and build frame
    logic shift;   // falling MDC: advance to next bit
    logic sample;  // rising MDC in read data phase: capture pin
    logic finish;  // falling MDC of last bit: transaction over
    logic drive;   // data line driven
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  logic        opIsRead,
  output logic        busy,
  output logic        mdc,
  output mdioStrobe_t strb
);

  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic             busyQ;
  logic             mdcQ;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             divWrap;
  logic             riseTick;
  logic             fallTick;
  logic             lastBit;
  logic             accept;

  generate
    if (DIV_HALF == 1) begin : g_divOne
      assign divWrap = 1'b1;
    end else begin : g_divN
      assign divWrap = (divCnt == DIV_W'(DIV_HALF - 1));
    end
  endgenerate

  assign accept   = cmdWrite && !busyQ;
  assign riseTick = busyQ && divWrap && !mdcQ;
  assign fallTick = busyQ && divWrap && mdcQ;
  assign lastBit  = (bitIdx == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (accept) begin
      busyQ  <= 1'b1;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busyQ) begin
      divCnt <= divWrap ? '0 : divCnt + DIV_W'(1);
      if (divWrap) mdcQ <= ~mdcQ;
      if (fallTick) begin
        bitIdx <= bitIdx + IDX_W'(1);
        if (lastBit) busyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.load   = accept;
    strb.shift  = fallTick && !lastBit;
    strb.sample = riseTick && opIsRead && (bitIdx >= IDX_W'(DATA_IDX));
    strb.finish = fallTick && lastBit;
    strb.drive  = busyQ && (!opIsRead || (bitIdx < IDX_W'(TURN_IDX)));
  end

  assign busy = busyQ;
  assign mdc  = mdcQ;

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter logic [4:0] DEFAULT_PHY = 5'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  mdioStrobe_t       strb,
  input  logic              busy,
  input  logic              mdioIn,
  output logic [31:0]       busRdata,
  output logic [31:0]       cmdWord,
  output logic              opIsRead,
  output logic              readValid,
  output logic              mdioOut
);

  logic [4:0]           phyDefQ;
  logic                 opReadQ;
  logic [4:0]           phyFieldQ;
  logic [4:0]           regFieldQ;
  logic [15:0]          dataQ;
  logic                 readValidQ;
  logic [FRAME_LEN-1:0] frameQ;
  logic [15:0]          capQ;
  logic [FRAME_LEN-1:0] newFrame;
  logic                 unusedWdata;

  assign unusedWdata = &{1'b0, busWdata[31:27]};

  always_comb begin
    newFrame = {{PRE_LEN{1'b1}}, 2'b01,
                busWdata[BIT_OPRD] ? 2'b10 : 2'b01,
                busWdata[20:16], busWdata[25:21], 2'b10,
                busWdata[BIT_OPRD] ? 16'h0000 : busWdata[15:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyDefQ <= DEFAULT_PHY;
    end else if (busWrEn && (busAddr == ADDR_W'(OFS_PHYDEF))) begin
      phyDefQ <= busWdata[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReadQ    <= 1'b0;
      phyFieldQ  <= '0;
      regFieldQ  <= '0;
      dataQ      <= '0;
      readValidQ <= 1'b0;
      frameQ     <= '1;
      capQ       <= '0;
    end else begin
      if (strb.load) begin
        opReadQ    <= busWdata[BIT_OPRD];
        regFieldQ  <= busWdata[25:21];
        phyFieldQ  <= busWdata[20:16];
        dataQ      <= busWdata[15:0];
        readValidQ <= 1'b0;
        frameQ     <= newFrame;
      end else if (strb.shift) begin
        frameQ <= {frameQ[FRAME_LEN-2:0], 1'b1};
      end
      if (strb.sample) capQ <= {capQ[14:0], mdioIn};
      if (strb.finish && opReadQ) begin
        dataQ      <= capQ;
        readValidQ <= 1'b1;
      end
    end
  end

  always_comb begin
    cmdWord = {3'b000, busy, readValidQ, opReadQ, regFieldQ, phyFieldQ, dataQ};
    if (busAddr == ADDR_W'(OFS_CMD))         busRdata = cmdWord;
    else if (busAddr == ADDR_W'(OFS_PHYDEF)) busRdata = {27'd0, phyDefQ};
    else                                     busRdata = '0;
  end

  assign opIsRead  = opReadQ;
  assign readValid = readValidQ;
  assign mdioOut   = busy ? frameQ[FRAME_LEN-1] : 1'b1;

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter int         DIV_HALF    = 2,
  parameter logic [4:0] DEFAULT_PHY = 5'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  mdioStrobe_t strb;
  logic        busy;
  logic        opIsRead;
  logic        readValid;
  logic        cmdWrite;
  logic [31:0] cmdWord;

  assign cmdWrite = busWrEn && (busAddr == ADDR_W'(OFS_CMD));
  assign mdioOe   = strb.drive;

  mdio_ctrl #(.DIV_HALF(DIV_HALF)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (cmdWrite),
    .opIsRead (opIsRead),
    .busy     (busy),
    .mdc      (mdc),
    .strb     (strb)
  );

  mdio_datapath #(.ADDR_W(ADDR_W), .DEFAULT_PHY(DEFAULT_PHY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .strb      (strb),
    .busy      (busy),
    .mdioIn    (mdioIn),
    .busRdata  (busRdata),
    .cmdWord   (cmdWord),
    .opIsRead  (opIsRead),
    .readValid (readValid),
    .mdioOut   (mdioOut)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic              busyFlag,
  input logic              readValidFlag,
  input logic [31:0]       cmdWord
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busyFlag |-> (!mdc && !mdioOe)); // R6

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> $stable(mdioOut)); // R5

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busyFlag && busWrEn && busAddr == ADDR_W'(OFS_CMD)) |=> $stable(cmdWord[26:16])); // R4

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!busyFlag && busWrEn && busAddr == ADDR_W'(OFS_CMD)) |=> (busyFlag && !readValidFlag)); // R8

  AST_PHY_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFS_PHYDEF)) |-> (busRdata[31:5] == 27'd0)); // R2

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    readValidFlag |-> !busyFlag); // R7

endmodule

bind mdio_mgmt mdio_mgmt_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .busWrEn       (busWrEn),
  .busAddr       (busAddr),
  .busRdata      (busRdata),
  .mdc           (mdc),
  .mdioOut       (mdioOut),
  .mdioOe        (mdioOe),
  .busyFlag      (busy),
  .readValidFlag (readValid),
  .cmdWord       (cmdWord)
);

// File: tb/test_mdio_mgmt.sv
module test_mdio_mgmt;

  localparam int HALF    = 2;
  localparam int TXN_CYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int risesSeen = 0;
  int riseA = 0;
  int riseB = 0;
  int acceptCyc = 0;
  logic        prevMdc = 1'b0;
  logic [63:0] capBits = '0;
  logic [63:0] capOe = '0;
  logic [15:0] phyResp = 16'h0000;

  always #2 clk = ~clk;

  mdio_mgmt #(.ADDR_W(4), .DIV_HALF(HALF), .DEFAULT_PHY(5'd1)) i_mdio_mgmt (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  always @(posedge clk) cyc <= cyc + 1;

  // Line monitor and PHY model, away from the active edge.
  always @(negedge clk) begin
    if (mdc && !prevMdc) begin
      if (risesSeen < 64) begin
        capBits[63 - risesSeen] = mdioOut;
        capOe[63 - risesSeen]   = mdioOe;
      end
      if (risesSeen == 0) riseA = cyc;
      if (risesSeen == 1) riseB = cyc;
      risesSeen = risesSeen + 1;
    end
    if (!mdc) begin
      if (risesSeen >= 48 && risesSeen < 64) mdioIn = phyResp[63 - risesSeen];
      else mdioIn = 1'b1;
    end
    prevMdc = mdc;
  end

  initial begin
    while (cyc < 100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  function automatic logic [31:0] mkCmd(input logic rd, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] dat);
    return {5'b0, rd, rg, phy, dat};
  endfunction

  function automatic logic [63:0] expFrame(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] dat);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, dat};
  endfunction

  task automatic startCmd(input logic [31:0] c);
    risesSeen = 0;
    busWrite(4'h4, c);
    acceptCyc = cyc;
  endtask

  task automatic waitIdle(output int doneAt);
    logic [31:0] r;
    doneAt = -1;
    for (int i = 0; i < 2000; i++) begin
      readReg(4'h4, r);
      if (!r[28]) begin doneAt = cyc - acceptCyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] r;
    readReg(4'h4, r);
    check("R1 busy", r[28], 1'b0);
    check("R1 rvalid", r[27], 1'b0);
    check("R1 mdc", mdc, 1'b0);
    check("R1 oe", mdioOe, 1'b0);
    readReg(4'h0, r);
    check("R1 phydef", r, 32'd1);
  endtask

  task automatic t_phyReg();
    logic [31:0] r;
    busWrite(4'h0, 32'hFFFF_FFEA);
    readReg(4'h0, r);
    check("R2 low5 only", r, 32'h0000_000A);
    busWrite(4'h0, 32'h1234_5673);
    readReg(4'h0, r);
    check("R2 rewrite", r, 32'h0000_0013);
  endtask

  task automatic t_write();
    logic [31:0] r;
    int doneAt;
    startCmd(mkCmd(1'b0, 5'h11, 5'h05, 16'hA5C3));
    readReg(4'h4, r);
    check("R3 busy set", r[28], 1'b1);
    check("R3 fields", r[26:0], {1'b0, 5'h05, 5'h11, 16'hA5C3});
    repeat (20) @(negedge clk);
    busWrite(4'h4, mkCmd(1'b1, 5'h1E, 5'h0A, 16'h0F0F));
    readReg(4'h4, r);
    check("R4 ignored while busy", r[26:0], {1'b0, 5'h05, 5'h11, 16'hA5C3});
    waitIdle(doneAt);
    check("R9 duration", doneAt, TXN_CYC);
    check("R5 write frame", capBits, expFrame(1'b0, 5'h11, 5'h05, 16'hA5C3));
    check("R10 driven all bits", capOe, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R6 mdc period", riseB - riseA, 2 * HALF);
    check("R6 idle mdc low", mdc, 1'b0);
    readReg(4'h4, r);
    check("R10 rvalid stays 0", r[27], 1'b0);
    check("R10 data kept", r[15:0], 16'hA5C3);
  endtask

  task automatic t_read();
    logic [31:0] r;
    int doneAt;
    phyResp = 16'h3C96;
    startCmd(mkCmd(1'b1, 5'h02, 5'h1F, 16'hFFFF));
    waitIdle(doneAt);
    check("R5 read header", capBits[63:18], expFrame(1'b1, 5'h02, 5'h1F, 16'h0) >> 18);
    check("R7 release", capOe, {46'h3FFF_FFFF_FFFF, 18'h0});
    readReg(4'h4, r);
    check("R7 rvalid", r[27], 1'b1);
    check("R7 data", r[15:0], 16'h3C96);
    check("R9 read duration", doneAt, TXN_CYC);
  endtask

  task automatic t_rvClear();
    logic [31:0] r;
    int doneAt;
    startCmd(mkCmd(1'b0, 5'h03, 5'h04, 16'h1111));
    readReg(4'h4, r);
    check("R8 rvalid cleared", r[27], 1'b0);
    waitIdle(doneAt);
  endtask

  task automatic t_collision();
    logic [31:0] r;
    phyResp = 16'h5AF0;
    risesSeen = 0;
    @(negedge clk);
    busAddr = 4'h4; busWdata = mkCmd(1'b1, 5'h07, 5'h09, 16'h0); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    repeat (TXN_CYC - 1) @(posedge clk);
    @(negedge clk);
    busWdata = mkCmd(1'b0, 5'h08, 5'h0C, 16'hBEEF); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    readReg(4'h4, r);
    check("R4 end-edge write ignored busy", r[28], 1'b0);
    check("R4 end-edge fields", r[26:16], {1'b1, 5'h09, 5'h07});
    check("R7 end-edge rvalid", r[27], 1'b1);
    check("R7 end-edge data", r[15:0], 16'h5AF0);
    busWrite(4'h4, mkCmd(1'b0, 5'h08, 5'h0C, 16'hBEEF));
    readReg(4'h4, r);
    check("R3 accepted after end", r[28:16], {1'b1, 1'b0, 1'b0, 5'h0C, 5'h08});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_phyReg();
    t_write();
    t_read();
    t_rvClear();
    t_collision();
    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule